// File: doc/BRIEF.md
# Pack Transfer Address Calculator

This block does the address arithmetic around one disk-pack data transfer. A start pulse brings in four values: the packed 18-bit disk address, the 18-bit memory address, the 18-bit two's-complement word count and the installed memory size. The block first checks the three address fields against the pack geometry. If every field is in range, it turns the address into a linear word offset on the pack. It then derives the transfer length and trims it so the transfer stops at the end of memory and at the end of the pack.

The block also produces the register values that must be written back once the transfer ends. These are the advanced word count, the advanced memory address, and a packed disk address that points at the first sector after the last word moved. That address is rounded up to a whole sector and limited to the last cylinder. Splitting the final sector number back into its fields is done one subtraction per clock, so the results arrive some cycles after the start pulse, marked by a single-cycle `ready`. The data movement itself is done elsewhere.

Top module: `pack_xfer_calc`

## Requirements
- R1: The disk address holds the sector in bits 3..0, the surface in bits 9..5 and the cylinder in bits 17..10. Bit 4 has no effect. `bad_sect` is raised for a sector of 10 or more, `bad_surf` for a surface of 20 or more, and `bad_cyl` for a cylinder of 203 or more.
- R2: If any of the three field flags is raised, the request finishes with `abort`=1 and `ready` one clock after the start edge. In that case `xfer_len`=0, `lin_addr`=0, `nexm`=`eop`=0, and `wc_out`, `ma_out`, `da_out` equal the inputs unchanged.
- R3: For a valid address, `lin_addr` = (((cylinder*20)+surface)*10+sector)*256.
- R4: Before trimming, the transfer length is 262144 minus `wc_in`. A word count of 0 therefore gives 262144.
- R5: If `ma_in` plus the length is strictly greater than `mem_size`, `nexm` is raised and the length becomes `mem_size` minus `ma_in`.
- R6: If `lin_addr` plus the length (after the R5 trim) is strictly greater than the pack size of 10393600 words, `eop` is raised and the length becomes the pack size minus `lin_addr`.
- R7: On a valid request, `wc_out` = (`wc_in` + length) mod 2^18 and `ma_out` = (`ma_in` + length) mod 2^18.
- R8: On a valid request, `da_out` packs the sector number ceil((`lin_addr` + length)/256), split back into cylinder, surface and sector in the R1 field layout, with bit 4 zero. A partly used sector rounds up to the next one.
- R9: If the final cylinder would be 203, `da_out` carries cylinder 202. Surface and sector keep their remainder values.
- R10: `busy` is high from the edge that accepts a valid start until `ready`. `ready` lasts one cycle. A start pulse while `busy` is high is ignored, and outputs stay held until the next accepted start.
- R11: After reset, `busy`, `ready` and every flag and result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted when not busy |
| da_in | input | 18 | Packed disk address |
| ma_in | input | 18 | Memory start address |
| wc_in | input | 18 | Two's-complement word count |
| mem_size | input | 19 | Installed memory size in words |
| busy | output | 1 | Splitting final address |
| ready | output | 1 | One-cycle result strobe |
| bad_sect | output | 1 | Sector out of range |
| bad_surf | output | 1 | Surface out of range |
| bad_cyl | output | 1 | Cylinder out of range |
| abort | output | 1 | Request rejected, done with unsafe |
| nexm | output | 1 | Length trimmed at end of memory |
| eop | output | 1 | Length trimmed at end of pack |
| lin_addr | output | 24 | Linear word address on the pack |
| xfer_len | output | 19 | Trimmed transfer length |
| wc_out | output | 18 | Word count after transfer |
| ma_out | output | 18 | Memory address after transfer |
| da_out | output | 18 | Packed disk address after transfer |

## Verification
The bench goes after the field boundaries 10, 20 and 203. A design with an off-by-one there would either accept a nonexistent sector or reject a real one. It drives a length ending exactly at memory size, where a `>=` comparison would trim wrongly, and a case where both trims apply in sequence, where the wrong trim order gives a length past the pack end. It checks a partial final sector, which a design that truncates instead of rounding would report one sector short. It checks the pack-end case, where a missing clamp would wrap to cylinder 203. A start pulse sent during the division must not disturb the result in progress.

// File: rtl/pack_xfer_calc.sv
module pack_xfer_calc #(
  parameter int SECT_N = 10,
  parameter int SURF_N = 20,
  parameter int CYL_N  = 203,
  parameter int WPS_LG = 8,
  localparam int AW    = 18,
  localparam int PACK  = (CYL_N * SURF_N * SECT_N) << WPS_LG,
  localparam int LW    = $clog2(PACK + (1 << AW) + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] da_in,
  input  logic [AW-1:0] ma_in,
  input  logic [AW-1:0] wc_in,
  input  logic [AW:0]   mem_size,
  output logic          busy,
  output logic          ready,
  output logic          bad_sect,
  output logic          bad_surf,
  output logic          bad_cyl,
  output logic          abort,
  output logic          nexm,
  output logic          eop,
  output logic [LW-1:0] lin_addr,
  output logic [AW:0]   xfer_len,
  output logic [AW-1:0] wc_out,
  output logic [AW-1:0] ma_out,
  output logic [AW-1:0] da_out
);
  localparam logic [LW-1:0] PACK_L  = LW'(PACK);
  localparam logic [LW-1:0] SURF_L  = LW'(SURF_N);
  localparam logic [LW-1:0] SECT_L  = LW'(SECT_N);
  localparam logic [LW-1:0] CYLSZ_L = LW'(SURF_N * SECT_N);
  localparam logic [7:0]    CMAX    = 8'(CYL_N - 1);

  logic [3:0] f_sect;
  logic [4:0] f_surf;
  logic [7:0] f_cyl;
  logic       bs_c, bf_c, bc_c;
  logic [LW-1:0] wa_c, fin_c;
  logic [AW:0]   len0_c, len1_c, len_c;
  logic          nexm_c, eop_c;

  assign f_sect = da_in[3:0];
  assign f_surf = da_in[9:5];
  assign f_cyl  = da_in[17:10];
  assign bs_c   = 32'(f_sect) >= SECT_N;
  assign bf_c   = 32'(f_surf) >= SURF_N;
  assign bc_c   = 32'(f_cyl)  >= CYL_N;

  assign wa_c   = (((LW'(f_cyl) * SURF_L) + LW'(f_surf)) * SECT_L + LW'(f_sect)) << WPS_LG;
  assign len0_c = (AW+1)'(1 << AW) - {1'b0, wc_in};
  assign nexm_c = ({1'b0, ma_in} + len0_c) > mem_size;
  assign len1_c = !nexm_c ? len0_c :
                  (mem_size > {1'b0, ma_in}) ? mem_size - {1'b0, ma_in} : '0;
  assign eop_c  = (wa_c + LW'(len1_c)) > PACK_L;
  assign len_c  = eop_c ? (AW+1)'(PACK_L - wa_c) : len1_c;
  assign fin_c  = wa_c + LW'(len_c);

  logic [LW-1:0] rem;
  logic [7:0]    cyl_cnt;
  logic [4:0]    surf_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; ready <= 1'b0; abort <= 1'b0;
      bad_sect <= 1'b0; bad_surf <= 1'b0; bad_cyl <= 1'b0;
      nexm <= 1'b0; eop <= 1'b0;
      lin_addr <= '0; xfer_len <= '0;
      wc_out <= '0; ma_out <= '0; da_out <= '0;
      rem <= '0; cyl_cnt <= '0; surf_cnt <= '0;
    end else begin
      ready <= 1'b0;
      if (!busy) begin
        if (start) begin
          bad_sect <= bs_c; bad_surf <= bf_c; bad_cyl <= bc_c;
          if (bs_c || bf_c || bc_c) begin
            abort <= 1'b1; ready <= 1'b1;
            nexm <= 1'b0; eop <= 1'b0;
            lin_addr <= '0; xfer_len <= '0;
            wc_out <= wc_in; ma_out <= ma_in; da_out <= da_in;
          end else begin
            abort <= 1'b0; busy <= 1'b1;
            nexm <= nexm_c; eop <= eop_c;
            lin_addr <= wa_c; xfer_len <= len_c;
            wc_out <= wc_in + len_c[AW-1:0];
            ma_out <= ma_in + len_c[AW-1:0];
            rem <= (fin_c >> WPS_LG) + LW'(|fin_c[WPS_LG-1:0]);
            cyl_cnt <= '0; surf_cnt <= '0;
          end
        end
      end else if (rem >= CYLSZ_L) begin
        rem <= rem - CYLSZ_L;
        cyl_cnt <= cyl_cnt + 8'd1;
      end else if (rem >= SECT_L) begin
        rem <= rem - SECT_L;
        surf_cnt <= surf_cnt + 5'd1;
      end else begin
        busy  <= 1'b0;
        ready <= 1'b1;
        da_out <= {(cyl_cnt > CMAX) ? CMAX : cyl_cnt, surf_cnt, 1'b0, rem[3:0]};
      end
    end
  end

  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  assert_busy_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(wc_out) && $stable(ma_out) && $stable(xfer_len) && $stable(lin_addr));

  assert_abort_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && abort) |-> (bad_sect || bad_surf || bad_cyl) && xfer_len == '0);

  assert_cyl_clamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !abort) |-> da_out[17:10] <= CMAX);

  assert_pack_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !abort) |-> (lin_addr + LW'(xfer_len)) <= PACK_L);

  assert_len_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> xfer_len <= (AW+1)'(1 << AW));
endmodule

// File: tb/test_pack_xfer_calc.sv
module test_pack_xfer_calc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [17:0] da_in = '0, ma_in = '0, wc_in = '0;
  logic [18:0] mem_size = '0;
  logic busy, ready, bad_sect, bad_surf, bad_cyl, abort, nexm, eop;
  logic [23:0] lin_addr;
  logic [18:0] xfer_len;
  logic [17:0] wc_out, ma_out, da_out;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  pack_xfer_calc i_pack_xfer_calc (
    .clk(clk), .rst_n(rst_n), .start(start),
    .da_in(da_in), .ma_in(ma_in), .wc_in(wc_in), .mem_size(mem_size),
    .busy(busy), .ready(ready), .bad_sect(bad_sect), .bad_surf(bad_surf),
    .bad_cyl(bad_cyl), .abort(abort), .nexm(nexm), .eop(eop),
    .lin_addr(lin_addr), .xfer_len(xfer_len),
    .wc_out(wc_out), .ma_out(ma_out), .da_out(da_out));

  localparam int NV = 11;
  localparam logic [17:0] T_DA [NV] = '{
    {8'd0, 5'd0, 1'b0, 4'd0},
    {8'd5, 5'd3, 1'b0, 4'd7},
    {8'd1, 5'd2, 1'b0, 4'd10},
    {8'd1, 5'd20, 1'b0, 4'd3},
    {8'd203, 5'd0, 1'b0, 4'd0},
    {8'd0, 5'd0, 1'b0, 4'd0},
    {8'd202, 5'd19, 1'b0, 4'd9},
    {8'd10, 5'd0, 1'b0, 4'd0},
    {8'd3, 5'd4, 1'b1, 4'd5},
    {8'd202, 5'd19, 1'b0, 4'd0},
    {8'd7, 5'd1, 1'b0, 4'd2}};
  localparam logic [17:0] T_MA [NV] = '{18'd0, 18'd100, 18'd5, 18'd5, 18'd5,
    18'h3FF00, 18'd0, 18'd0, 18'd7, 18'h30000, 18'd4000};
  localparam logic [17:0] T_WC [NV] = '{18'h3FF00, 18'h3FED4, 18'h3FF00, 18'h3FF00,
    18'h3FF00, 18'h3FE00, 18'h3FE00, 18'h00000, 18'h3FFFF, 18'h00000, 18'h3F830};
  localparam logic [18:0] T_MS [NV] = '{19'h40000, 19'h40000, 19'h40000, 19'h40000,
    19'h40000, 19'h40000, 19'h40000, 19'h40000, 19'h40000, 19'h40000, 19'd5000};
  localparam logic [2:0] T_FL [NV] = '{3'b000, 3'b000, 3'b100, 3'b100, 3'b100,
    3'b010, 3'b001, 3'b000, 3'b000, 3'b011, 3'b010};

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(input logic [17:0] da, ma, wc, input logic [18:0] ms,
                       output int e_bs, e_bf, e_bc, e_wa, e_len, e_nx, e_ep,
                       output int e_wc, e_ma, e_da);
    int s, f, c, fs, cy;
    s = int'(da[3:0]); f = int'(da[9:5]); c = int'(da[17:10]);
    e_bs = int'(s >= 10); e_bf = int'(f >= 20); e_bc = int'(c >= 203);
    if (e_bs + e_bf + e_bc > 0) begin
      e_wa = 0; e_len = 0; e_nx = 0; e_ep = 0;
      e_wc = int'(wc); e_ma = int'(ma); e_da = int'(da);
    end else begin
      e_wa = ((c * 20 + f) * 10 + s) * 256;
      e_len = 262144 - int'(wc);
      e_nx = int'(int'(ma) + e_len > int'(ms));
      if (e_nx != 0) e_len = int'(ms) - int'(ma);
      e_ep = int'(e_wa + e_len > 10393600);
      if (e_ep != 0) e_len = 10393600 - e_wa;
      e_wc = (int'(wc) + e_len) % 262144;
      e_ma = (int'(ma) + e_len) % 262144;
      fs = (e_wa + e_len + 255) / 256;
      cy = fs / 200;
      if (cy > 202) cy = 202;
      e_da = (cy << 10) | (((fs % 200) / 10) << 5) | (fs % 10);
    end
  endtask

  task automatic wait_ready(output bit seen);
    seen = 0;
    for (int k = 0; k < 1000 && !seen; k++) begin
      @(negedge clk);
      if (ready) seen = 1;
    end
  endtask

  task automatic run_vec(input int i);
    int e_bs, e_bf, e_bc, e_wa, e_len, e_nx, e_ep, e_wc, e_ma, e_da;
    bit seen;
    model(T_DA[i], T_MA[i], T_WC[i], T_MS[i], e_bs, e_bf, e_bc, e_wa, e_len,
          e_nx, e_ep, e_wc, e_ma, e_da);
    @(negedge clk);
    da_in = T_DA[i]; ma_in = T_MA[i]; wc_in = T_WC[i]; mem_size = T_MS[i];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = ready;
    if (!seen) wait_ready(seen);
    chk(seen, "R10 ready seen", longint'(seen), 1);
    chk({bad_sect, bad_surf, bad_cyl} == {e_bs[0], e_bf[0], e_bc[0]}, "R1 field flags",
        {bad_sect, bad_surf, bad_cyl}, {e_bs[0], e_bf[0], e_bc[0]});
    chk({abort, nexm, eop} == T_FL[i], "R2 R5 R6 table flags",
        {abort, nexm, eop}, T_FL[i]);
    chk(int'(lin_addr) == e_wa, "R3 linear address", lin_addr, e_wa);
    chk(int'(xfer_len) == e_len, "R4 R5 R6 length", xfer_len, e_len);
    chk(int'(wc_out) == e_wc && int'(ma_out) == e_ma, "R7 count and address",
        {wc_out, ma_out}, {e_wc[17:0], e_ma[17:0]});
    chk(int'(da_out) == e_da, "R8 R9 final disk address", da_out, e_da);
    @(negedge clk);
    chk(!ready, "R10 single ready", ready, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    chk({busy, ready, abort, nexm, eop, bad_sect, bad_surf, bad_cyl} == '0,
        "R11 reset flags", {busy, ready, abort, nexm, eop}, 0);
    chk(lin_addr == '0 && xfer_len == '0 && da_out == '0 && wc_out == '0 && ma_out == '0,
        "R11 reset results", da_out, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(i);

    // R1: bit 4 ignored, compare against same address without it
    run_vec(8);
    chk(lin_addr == 24'(((3 * 20 + 4) * 10 + 5) * 256), "R1 bit4 ignored", lin_addr,
        ((3 * 20 + 4) * 10 + 5) * 256);

    // R2: abort returns ready one clock after the start edge
    @(negedge clk);
    da_in = {8'd0, 5'd0, 1'b0, 4'd15}; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(ready && abort && !busy, "R2 abort latency", {ready, abort, busy}, 3'b110);

    // R10: start while busy is ignored
    @(negedge clk);
    da_in = T_DA[6]; ma_in = T_MA[6]; wc_in = T_WC[6]; mem_size = T_MS[6];
    start = 1'b1;
    @(negedge clk);
    chk(busy, "R10 busy after start", busy, 1);
    da_in = {8'd1, 5'd2, 1'b0, 4'd10}; ma_in = 18'd55; wc_in = 18'h3FFF0;
    @(negedge clk);
    start = 1'b0;
    wait_ready(seen);
    chk(seen && !abort && eop, "R10 busy start ignored", {abort, eop}, 2'b01);
    chk(da_out == {8'd202, 5'd0, 1'b0, 4'd0}, "R9 clamp after busy start", da_out,
        {8'd202, 5'd0, 1'b0, 4'd0});
    chk(xfer_len == 19'd256, "R6 length after busy start", xfer_len, 256);
    repeat (3) @(negedge clk);
    chk(xfer_len == 19'd256 && da_out == {8'd202, 5'd0, 1'b0, 4'd0}, "R10 outputs held",
        xfer_len, 256);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule